// File: doc/BRIEF.md
# Address Breakpoint Match Unit

This block watches two address streams, one for data accesses and one for instruction fetches, and compares them against two data breakpoints and two instruction breakpoints. An address is not compared in one wide comparison. It is split into seven fixed groups, and each group produces its own equal bit. A breakpoint fires only when all seven group bits are set. A per-group mask field in the shared breakpoint control word can turn any group into a don't-care, which lets a breakpoint cover a range of addresses.

Data breakpoint hits count only while a load or store is active and the data-breakpoint valid is high. Instruction breakpoints report a raw match and a taken flag. The taken flag also needs the global enable bit of the control word. All results are registered once. They freeze while the pipeline hold is high and clear on reset. Trap generation and the writing of the breakpoint registers are left to the surrounding logic.

Top module: `brk_match`

## Requirements
- R1: The address splits into group 6 = bits 31..13, group 5 = bit 12, group 4 = bits 11..4, and groups 3, 2, 1, 0 = the address bit with the same number. An unmasked difference in any one group blocks the match.
- R2: A breakpoint matches when its seven group-equal bits are all 1. An address identical to the breakpoint address always matches.
- R3: For breakpoint k, the control bits [7k+6:7k] are its mask, with k = 0,1 for data breakpoints 0,1 and k = 2,3 for instruction breakpoints 0,1. When mask bit g is 1, group g counts as equal whatever the address holds.
- R4: `dbp_hit[k]` is set only when data breakpoint k matches `dat_addr` while both `dat_ldst` and `dat_bp_vld` are 1.
- R5: `ibp_match[j]` reports instruction breakpoint j matching `ins_addr` with no further condition. `ibp_taken[j]` equals that match ANDed with control bit 31.
- R6: Every output shows the result for the inputs sampled at the rising clock edge that follows them. It does not change before that edge.
- R7: While `hold` is 1 at a rising edge, all outputs keep their previous values.
- R8: While `rst_n` is 0, every output is 0.
- R9: The two data breakpoints and the two instruction breakpoints are independent. A match on one sets only its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Pipeline hold; freezes the outputs |
| dat_addr | input | 32 | Data access address |
| dat_ldst | input | 1 | Load or store active this cycle |
| dat_bp_vld | input | 1 | Data-breakpoint valid qualifier |
| ins_addr | input | 32 | Instruction address |
| dbp_addr | input | 64 | Data breakpoint addresses, breakpoint k in bits [32k+31:32k] |
| ibp_addr | input | 64 | Instruction breakpoint addresses, breakpoint j in bits [32j+31:32j] |
| bp_ctl | input | 32 | Breakpoint control: four 7-bit masks and the enable in bit 31 |
| dbp_hit | output | 2 | Registered data breakpoint hits |
| ibp_match | output | 2 | Registered raw instruction breakpoint matches |
| ibp_taken | output | 2 | Registered enabled instruction breakpoint flags |

## Verification
Each result is due exactly one rising edge after its inputs are applied. The bench drives at a falling edge and samples at the next falling edge, so the single register stage has settled by then. The latency check also samples just before that rising edge and expects the old value. A hold check drives new addresses while `hold` is high and expects the outputs to stay unchanged over the held edge. After `hold` drops, the result is due one edge later.

// File: rtl/brk_pkg.sv
package brk_pkg;
   localparam int ADDR_W = 32;
   localparam int GRP_N  = 7;
   localparam int EN_BIT = 31;

   // Lowest address bit of a compare group
   function automatic int grp_lo(input int g);
      case (g)
         6:       return 13;
         5:       return 12;
         4:       return 4;
         default: return g;
      endcase
   endfunction

   // Highest address bit of a compare group
   function automatic int grp_hi(input int g);
      case (g)
         6:       return 31;
         5:       return 12;
         4:       return 11;
         default: return g;
      endcase
   endfunction
endpackage

// File: rtl/brk_grp_cmp.sv
module brk_grp_cmp
   import brk_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] bp,
   input  logic [GRP_N-1:0]  mask,
   output logic              hit
);
   logic [GRP_N-1:0] eq;

   for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      localparam int LO = grp_lo(g);
      localparam int HI = grp_hi(g);
      assign eq[g] = mask[g] | (addr[HI:LO] == bp[HI:LO]);
   end

   assign hit = (eq == {GRP_N{1'b1}});

   // R2: identical address always matches
   always_comb p_equal_hits_r2: assert (addr != bp || hit);
   // R3: fully masked breakpoint matches every address
   always_comb p_mask_all_r3: assert (!(&mask) || hit);
endmodule

// File: rtl/brk_hold_reg.sv
module brk_hold_reg #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!hold) q <= d;
   end

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q));
   p_reset_clear_r8: assert property (@(posedge clk)
      !rst_n |=> (q == '0));
endmodule

// File: rtl/brk_match.sv
module brk_match
   import brk_pkg::*;
#(
   parameter int NUM_DBP = 2,
   parameter int NUM_IBP = 2,
   parameter int CTL_W   = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hold,
   input  logic [ADDR_W-1:0]           dat_addr,
   input  logic                        dat_ldst,
   input  logic                        dat_bp_vld,
   input  logic [ADDR_W-1:0]           ins_addr,
   input  logic [NUM_DBP*ADDR_W-1:0]   dbp_addr,
   input  logic [NUM_IBP*ADDR_W-1:0]   ibp_addr,
   input  logic [CTL_W-1:0]            bp_ctl,
   output logic [NUM_DBP-1:0]          dbp_hit,
   output logic [NUM_IBP-1:0]          ibp_match,
   output logic [NUM_IBP-1:0]          ibp_taken
);
   localparam int MASK_TOP = (NUM_DBP + NUM_IBP) * GRP_N;
   localparam int OUT_W    = NUM_DBP + 2 * NUM_IBP;

   if (CTL_W != EN_BIT + 1) begin : g_bad_ctl
      $error("brk_match: control word must be %0d bits", EN_BIT + 1);
   end
   if (MASK_TOP > EN_BIT) begin : g_bad_masks
      $error("brk_match: mask fields overlap the enable bit");
   end

   if (MASK_TOP < EN_BIT) begin : g_spare
      logic ctl_unused;
      assign ctl_unused = ^bp_ctl[EN_BIT-1:MASK_TOP];
   end

   logic [NUM_DBP-1:0] dmatch;
   logic [NUM_IBP-1:0] imatch;

   for (genvar k = 0; k < NUM_DBP; k++) begin : g_dbp
      brk_grp_cmp u_cmp (
         .addr (dat_addr),
         .bp   (dbp_addr[k*ADDR_W +: ADDR_W]),
         .mask (bp_ctl[k*GRP_N +: GRP_N]),
         .hit  (dmatch[k])
      );
   end

   for (genvar j = 0; j < NUM_IBP; j++) begin : g_ibp
      brk_grp_cmp u_cmp (
         .addr (ins_addr),
         .bp   (ibp_addr[j*ADDR_W +: ADDR_W]),
         .mask (bp_ctl[(NUM_DBP+j)*GRP_N +: GRP_N]),
         .hit  (imatch[j])
      );
   end

   logic [NUM_DBP-1:0] dhit_d;
   logic [NUM_IBP-1:0] itaken_d;
   logic [OUT_W-1:0]   q;

   assign dhit_d   = dmatch & {NUM_DBP{dat_ldst & dat_bp_vld}};
   assign itaken_d = imatch & {NUM_IBP{bp_ctl[EN_BIT]}};

   brk_hold_reg #(.W(OUT_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .d     ({dhit_d, imatch, itaken_d}),
      .q     (q)
   );

   assign dbp_hit   = q[OUT_W-1 -: NUM_DBP];
   assign ibp_match = q[NUM_IBP +: NUM_IBP];
   assign ibp_taken = q[NUM_IBP-1:0];

   p_taken_sub_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ibp_taken & ~ibp_match) == '0);
   p_taken_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ibp_taken) && !$past(hold)) |-> $past(bp_ctl[EN_BIT]));
   p_dhit_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|dbp_hit) && !$past(hold)) |-> $past(dat_ldst && dat_bp_vld));
endmodule

// File: tb/brk_match_test.sv
module brk_match_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0;
   logic [31:0] dat_addr = '0;
   logic        dat_ldst = 1'b0;
   logic        dat_bp_vld = 1'b0;
   logic [31:0] ins_addr = '0;
   logic [63:0] dbp_addr;
   logic [63:0] ibp_addr;
   logic [31:0] bp_ctl = '0;
   logic [1:0]  dbp_hit, ibp_match, ibp_taken;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   assign dbp_addr = {32'hABCD_0000, 32'h1234_5678};
   assign ibp_addr = {32'hFFFF_E00F, 32'h0000_2010};

   brk_match uut (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .dat_addr(dat_addr), .dat_ldst(dat_ldst), .dat_bp_vld(dat_bp_vld),
      .ins_addr(ins_addr), .dbp_addr(dbp_addr), .ibp_addr(ibp_addr),
      .bp_ctl(bp_ctl), .dbp_hit(dbp_hit), .ibp_match(ibp_match),
      .ibp_taken(ibp_taken)
   );

   // {dat_addr, ins_addr, bp_ctl, ldst, vld, expected {dhit, imatch, itaken}}
   localparam int NV = 11;
   localparam logic [103:0] VEC [NV] = '{
      {32'h1234_5678, 32'h0000_2010, 32'h8000_0000, 1'b1, 1'b1, 6'b01_01_01},
      {32'hABCD_0000, 32'hFFFF_E00F, 32'h8000_0000, 1'b1, 1'b1, 6'b10_10_10},
      {32'h1234_5678, 32'h0000_2010, 32'h0000_0000, 1'b1, 1'b1, 6'b01_01_00},
      {32'h1234_5678, 32'h0000_2010, 32'h8000_0000, 1'b0, 1'b1, 6'b00_01_01},
      {32'h1234_5678, 32'h0000_2010, 32'h8000_0000, 1'b1, 1'b0, 6'b00_01_01},
      {32'h1234_4678, 32'h0000_0010, 32'h8000_0000, 1'b1, 1'b1, 6'b00_00_00},
      {32'h1234_4678, 32'h0000_0010, 32'h8010_0020, 1'b1, 1'b1, 6'b01_01_01},
      {32'h1234_5668, 32'h0000_2011, 32'h8000_0000, 1'b1, 1'b1, 6'b00_00_00},
      {32'h1234_567C, 32'h0000_2018, 32'h8000_0000, 1'b1, 1'b1, 6'b00_00_00},
      {32'h0000_0000, 32'h0000_0000, 32'h8FE0_3F80, 1'b1, 1'b1, 6'b10_10_10},
      {32'h1234_567A, 32'hFFFF_F00F, 32'h8000_0000, 1'b1, 1'b1, 6'b00_00_00}
   };
   localparam string TAG [NV] = '{"R2", "R9", "R5", "R4", "R4", "R1",
                                   "R3", "R1", "R1", "R3", "R1"};

   task automatic check(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {dbp_hit, ibp_match, ibp_taken};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs %b expected %b", req, act, exp);
      end
   endtask

   task automatic drive(input logic [103:0] v);
      dat_addr   = v[103:72];
      ins_addr   = v[71:40];
      bp_ctl     = v[39:8];
      dat_ldst   = v[7];
      dat_bp_vld = v[6];
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8", 6'b0);                      // reset state
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         @(negedge clk);
         check(TAG[i], VEC[i][5:0]);
      end

      // R6: result not visible before the next rising edge
      @(negedge clk);
      drive(VEC[0]);
      #9;
      check("R6", 6'b0);
      @(negedge clk);
      check("R6", 6'b01_01_01);

      // R7: hold freezes outputs while inputs change
      hold = 1'b1;
      drive(VEC[1]);
      @(negedge clk);
      check("R7", 6'b01_01_01);
      @(negedge clk);
      check("R7", 6'b01_01_01);
      hold = 1'b0;
      @(negedge clk);
      check("R7", 6'b10_10_10);

      // R8: reset in mid-run clears everything
      rst_n = 1'b0;
      #1;
      check("R8", 6'b0);
      @(negedge clk);
      check("R8", 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", 6'b10_10_10);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule